// File: doc/BRIEF.md
# Receive-Path Frame Byte Tamper

This block sits in the byte-wide receive path of an Ethernet frame modifier. It is one of the test blocks that a test selector switches on. While its command enable is high, it overwrites one chosen byte in each of a set number of frames, then reports that it has finished.

Receive bytes arrive already assembled. Each byte comes with a one-cycle strobe, a frame-active level and a field code that says which part of the frame the byte belongs to. The block forwards every byte with one clock of latency, and only the selected byte of a qualifying frame is changed. Once armed, it acts only on frames that begin after the enable was seen. A non-zero match address limits it to frames whose destination address equals that address; an all-zero address makes it act on every frame. For each frame it changes, it raises a request for a later stage to recompute the frame check sequence. While the address comparison is still open on a conditional frame, it raises a hold hint for the delay stage further down the path.

Top module: `rx_byte_tamper`

## Requirements
- R1: `rxByteOut` and `rxStrobeOut` are the previous cycle's `rxByteIn` and `rxStrobeIn`, except for the single replaced byte. The strobe is always copied, in both its high and low cycles.
- R2: Field codes are 0 idle, 1 preamble, 2 start delimiter, 3 destination, 4 source, 5 type/length, 6 payload and 7 check sequence. Strobed bytes with codes 0 to 2 are not counted. Position 0 is the first strobed byte with code 3 or higher. Only the byte at position `cmdBytePos` is replaced, and it is replaced by `cmdNewValue`.
- R3: A frame is selected only if `cmdEnable` is high and `testDone` is low in the cycle in which `rxFrameActive` rises. A frame already running when the enable rises passes through unchanged.
- R4: When `cmdEnable` is low, no byte is replaced. On the next cycle `testDone` is low and the modified-frame count is cleared.
- R5: When `matchMac` is all zero, every selected frame qualifies, and `delayByte` is never asserted.
- R6: When `matchMac` is non-zero, destination bytes 0 to 5 are compared with `matchMac[47:40]` down to `matchMac[7:0]`, in that order. A position of 6 or more is replaced only if all six bytes match.
- R7: With a non-zero `matchMac` and a position below 6, the byte is replaced if destination bytes 0 up to and including that position match. On a selected conditional frame, `delayByte` is high together with output body byte k (k < 6) when bytes 0 to k-1 matched. It is low from body byte 6 on.
- R8: `fixChecksum` rises in the same cycle as the replaced byte leaves the block. It stays high until the cycle after `rxFrameActive` falls.
- R9: `testDone` rises together with the replaced byte of the Nth modified frame, where N is `cmdFrameCount` and a count of 0 acts as 1. Frames that end before the position is reached, and frames that fail the address match, are not counted. `testDone` holds until the enable is withdrawn, and no new frame is selected while it is high.
- R10: While reset is high, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdEnable | input | 1 | Test enable from the selector |
| cmdFrameCount | input | CNT_W | Number of frames to modify (0 acts as 1) |
| cmdBytePos | input | POS_W | Position of the byte to replace, 0 = first destination byte |
| cmdNewValue | input | 8 | Replacement value |
| matchMac | input | 8*MAC_BYTES | Destination address filter; all zero disables the filter |
| rxByteIn | input | 8 | Assembled receive byte |
| rxStrobeIn | input | 1 | One-cycle new-byte strobe |
| rxFrameActive | input | 1 | High for the whole frame |
| rxFieldState | input | 3 | Field code of the current byte |
| rxByteOut | output | 8 | Forwarded or replaced byte |
| rxStrobeOut | output | 1 | Delayed new-byte strobe |
| fixChecksum | output | 1 | Frame check sequence must be recomputed |
| delayByte | output | 1 | Address match still open; hold hint for the delay stage |
| testDone | output | 1 | Requested number of frames has been modified |

## Verification
Traffic with the enable low checks that frames pass through unchanged. Unconditional runs at positions 0, in the middle and past the end of short frames separate correct position counting from off-by-one errors, and show that short frames are not counted. Conditional frames that mismatch at different address bytes, with positions inside and outside the address, separate prefix matching from full matching and show when the hold hint is set. Toggling the enable in the middle of a frame tests arming at frame start and immediate withdrawal. A seeded random mix of lengths, positions, counts and filters then exercises all of these together.

// File: rtl/rx_tamper_pkg.sv
package rx_tamper_pkg;

  // Field code carried alongside each received byte
  typedef enum logic [2:0] {
    FLD_IDLE     = 3'd0,
    FLD_PREAMBLE = 3'd1,
    FLD_SFD      = 3'd2,
    FLD_DEST     = 3'd3,
    FLD_SRC      = 3'd4,
    FLD_TYPE     = 3'd5,
    FLD_DATA     = 3'd6,
    FLD_FCS      = 3'd7
  } rxField_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic replace;
    logic delay;
  } tamperCtl_t;

endpackage

// File: rtl/rx_tamper_dp.sv
module rx_tamper_dp
  import rx_tamper_pkg::*;
#(
  parameter int POS_W     = 11,
  parameter int MAC_BYTES = 6,
  localparam int MAC_W    = 8 * MAC_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rxByteIn,
  input  logic             rxStrobeIn,
  input  logic [7:0]       newValue,
  input  logic [MAC_W-1:0] matchMac,
  input  logic [POS_W-1:0] posCnt,
  input  tamperCtl_t       ctl,
  output logic             curByteEq,
  output logic             macIsZero,
  output logic [7:0]       rxByteOut,
  output logic             rxStrobeOut,
  output logic             delayByte
);

  logic [MAC_BYTES-1:0] byteEq;

  // One comparator per address byte, byte 0 in the top bits (R6)
  for (genvar g = 0; g < MAC_BYTES; g++) begin : gCmp
    assign byteEq[g] = (rxByteIn == matchMac[MAC_W-1-8*g -: 8]);
  end

  // Select the comparator for the current position
  always_comb begin
    curByteEq = 1'b0;
    for (int i = 0; i < MAC_BYTES; i++) begin
      if (posCnt == POS_W'(i)) curByteEq = byteEq[i];
    end
  end

  assign macIsZero = (matchMac == '0);

  // Registered output stage, one clock of latency (R1)
  always_ff @(posedge clk) begin
    if (rst) begin
      rxByteOut   <= '0;
      rxStrobeOut <= 1'b0;
      delayByte   <= 1'b0;
    end else begin
      rxByteOut   <= ctl.replace ? newValue : rxByteIn;
      rxStrobeOut <= rxStrobeIn;
      delayByte   <= ctl.delay;
    end
  end

endmodule

// File: rtl/rx_tamper_ctrl.sv
module rx_tamper_ctrl
  import rx_tamper_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int POS_W     = 11,
  parameter int MAC_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdEnable,
  input  logic [CNT_W-1:0] cmdFrameCount,
  input  logic [POS_W-1:0] cmdBytePos,
  input  logic             rxStrobeIn,
  input  logic             rxFrameActive,
  input  logic [2:0]       rxFieldState,
  input  logic             curByteEq,
  input  logic             macIsZero,
  output tamperCtl_t       ctl,
  output logic [POS_W-1:0] posCnt,
  output logic             fixChecksum,
  output logic             testDone
);

  localparam logic [POS_W-1:0] MAC_END = POS_W'(MAC_BYTES);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             activeQ;
  logic             frameSel;
  logic             prefixOk;
  logic             hitQ;
  logic [CNT_W-1:0] modCnt;

  logic             frameStart;
  logic             bodyByte;
  logic             inMacWin;
  logic             macOk;
  logic             replaceNow;
  logic [CNT_W:0]   cntNext;
  logic             reached;

  assign frameStart = rxFrameActive && !activeQ;
  // Preamble and delimiter bytes are not counted (R2)
  assign bodyByte   = rxStrobeIn && rxFrameActive && (rxFieldState >= FLD_DEST);
  assign inMacWin   = (posCnt < MAC_END);

  // Unconditional, or matched so far including the current byte (R5, R6, R7)
  assign macOk      = macIsZero || (prefixOk && (!inMacWin || curByteEq));

  assign replaceNow = frameSel && cmdEnable && !hitQ && bodyByte &&
                      (posCnt == cmdBytePos) && macOk;

  assign ctl.replace = replaceNow;
  // Hold hint while the address comparison is still open (R7)
  assign ctl.delay   = frameSel && cmdEnable && !macIsZero && inMacWin && prefixOk;

  assign cntNext = {1'b0, modCnt} + 1'b1;
  assign reached = (cntNext >= {1'b0, cmdFrameCount});

  // Per-frame state: selection at frame start, position, address prefix (R3)
  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ  <= 1'b0;
      frameSel <= 1'b0;
      posCnt   <= '0;
      prefixOk <= 1'b1;
      hitQ     <= 1'b0;
    end else begin
      activeQ <= rxFrameActive;
      if (frameStart) begin
        frameSel <= cmdEnable && !testDone;
        posCnt   <= '0;
        prefixOk <= 1'b1;
        hitQ     <= 1'b0;
      end else if (!rxFrameActive) begin
        frameSel <= 1'b0;
      end else if (bodyByte) begin
        if (posCnt != POS_MAX) posCnt <= posCnt + 1'b1;
        if (inMacWin && !curByteEq) prefixOk <= 1'b0;
        if (replaceNow) hitQ <= 1'b1;
      end
    end
  end

  // Modified-frame count and completion (R4, R9)
  always_ff @(posedge clk) begin
    if (rst) begin
      modCnt   <= '0;
      testDone <= 1'b0;
    end else if (!cmdEnable) begin
      modCnt   <= '0;
      testDone <= 1'b0;
    end else if (replaceNow) begin
      if (modCnt != CNT_MAX) modCnt <= modCnt + 1'b1;
      if (reached) testDone <= 1'b1;
    end
  end

  // Checksum fix request, held to frame end (R8)
  always_ff @(posedge clk) begin
    if (rst) begin
      fixChecksum <= 1'b0;
    end else if (replaceNow) begin
      fixChecksum <= 1'b1;
    end else if (!rxFrameActive) begin
      fixChecksum <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_byte_tamper.sv
module rx_byte_tamper
  import rx_tamper_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int POS_W     = 11,
  parameter int MAC_BYTES = 6,
  localparam int MAC_W    = 8 * MAC_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdEnable,
  input  logic [CNT_W-1:0] cmdFrameCount,
  input  logic [POS_W-1:0] cmdBytePos,
  input  logic [7:0]       cmdNewValue,
  input  logic [MAC_W-1:0] matchMac,
  input  logic [7:0]       rxByteIn,
  input  logic             rxStrobeIn,
  input  logic             rxFrameActive,
  input  logic [2:0]       rxFieldState,
  output logic [7:0]       rxByteOut,
  output logic             rxStrobeOut,
  output logic             fixChecksum,
  output logic             delayByte,
  output logic             testDone
);

  tamperCtl_t       ctl;
  logic [POS_W-1:0] posCnt;
  logic             curByteEq;
  logic             macIsZero;

  rx_tamper_ctrl #(
    .CNT_W    (CNT_W),
    .POS_W    (POS_W),
    .MAC_BYTES(MAC_BYTES)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmdEnable    (cmdEnable),
    .cmdFrameCount(cmdFrameCount),
    .cmdBytePos   (cmdBytePos),
    .rxStrobeIn   (rxStrobeIn),
    .rxFrameActive(rxFrameActive),
    .rxFieldState (rxFieldState),
    .curByteEq    (curByteEq),
    .macIsZero    (macIsZero),
    .ctl          (ctl),
    .posCnt       (posCnt),
    .fixChecksum  (fixChecksum),
    .testDone     (testDone)
  );

  rx_tamper_dp #(
    .POS_W    (POS_W),
    .MAC_BYTES(MAC_BYTES)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .rxByteIn   (rxByteIn),
    .rxStrobeIn (rxStrobeIn),
    .newValue   (cmdNewValue),
    .matchMac   (matchMac),
    .posCnt     (posCnt),
    .ctl        (ctl),
    .curByteEq  (curByteEq),
    .macIsZero  (macIsZero),
    .rxByteOut  (rxByteOut),
    .rxStrobeOut(rxStrobeOut),
    .delayByte  (delayByte)
  );

endmodule

// File: rtl/rx_tamper_chk.sv
module rx_tamper_chk #(
  parameter int MAC_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             cmdEnable,
  input logic [MAC_W-1:0] matchMac,
  input logic [7:0]       rxByteIn,
  input logic             rxStrobeIn,
  input logic             rxFrameActive,
  input logic [7:0]       rxByteOut,
  input logic             rxStrobeOut,
  input logic             fixChecksum,
  input logic             delayByte,
  input logic             testDone
);

  logic pastValid;
  always_ff @(posedge clk) begin
    if (rst) pastValid <= 1'b0;
    else     pastValid <= 1'b1;
  end

  AST_STROBE_ECHO: assert property (@(posedge clk) disable iff (rst)
    pastValid |-> (rxStrobeOut == $past(rxStrobeIn))); // R1

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !$past(rxFrameActive)) |-> (rxByteOut == $past(rxByteIn))); // R2

  AST_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !$past(cmdEnable)) |-> (rxByteOut == $past(rxByteIn))); // R4

  AST_OFF_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !$past(cmdEnable)) |-> !testDone); // R4

  AST_NO_HOLD_UNCOND: assert property (@(posedge clk) disable iff (rst)
    (pastValid && ($past(matchMac) == '0)) |-> !delayByte); // R5

  AST_FIX_WITH_BYTE: assert property (@(posedge clk) disable iff (rst)
    (pastValid && $rose(fixChecksum)) |-> (rxStrobeOut && $past(rxFrameActive))); // R8

  AST_DONE_WITH_BYTE: assert property (@(posedge clk) disable iff (rst)
    (pastValid && $rose(testDone)) |-> (rxStrobeOut && $past(cmdEnable))); // R9

endmodule

bind rx_byte_tamper rx_tamper_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmdEnable    (cmdEnable),
  .matchMac     (matchMac),
  .rxByteIn     (rxByteIn),
  .rxStrobeIn   (rxStrobeIn),
  .rxFrameActive(rxFrameActive),
  .rxByteOut    (rxByteOut),
  .rxStrobeOut  (rxStrobeOut),
  .fixChecksum  (fixChecksum),
  .delayByte    (delayByte),
  .testDone     (testDone)
);

// File: tb/rx_byte_tamper_tb.sv
module rx_byte_tamper_tb;

  localparam int CNT_W     = 8;
  localparam int POS_W     = 11;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = 8 * MAC_BYTES;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmdEnable = 1'b0;
  logic [CNT_W-1:0] cmdFrameCount = '0;
  logic [POS_W-1:0] cmdBytePos = '0;
  logic [7:0]       cmdNewValue = '0;
  logic [MAC_W-1:0] matchMac = '0;
  logic [7:0]       rxByteIn = '0;
  logic             rxStrobeIn = 1'b0;
  logic             rxFrameActive = 1'b0;
  logic [2:0]       rxFieldState = '0;
  logic [7:0]       rxByteOut;
  logic             rxStrobeOut;
  logic             fixChecksum;
  logic             delayByte;
  logic             testDone;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit mDone = 0;
  int mCount = 0;

  logic [7:0] frm [128];
  logic [2:0] fld [128];

  always #2 clk = ~clk;

  rx_byte_tamper u_dut (
    .clk(clk), .rst(rst), .cmdEnable(cmdEnable), .cmdFrameCount(cmdFrameCount),
    .cmdBytePos(cmdBytePos), .cmdNewValue(cmdNewValue), .matchMac(matchMac),
    .rxByteIn(rxByteIn), .rxStrobeIn(rxStrobeIn), .rxFrameActive(rxFrameActive),
    .rxFieldState(rxFieldState), .rxByteOut(rxByteOut), .rxStrobeOut(rxStrobeOut),
    .fixChecksum(fixChecksum), .delayByte(delayByte), .testDone(testDone)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] macByte(input int i);
    return matchMac[MAC_W-1-8*i -: 8];
  endfunction

  function automatic logic [2:0] fieldOf(input int k, input int len);
    if (k < 6)        return 3'd3;
    if (k < 12)       return 3'd4;
    if (k < 14)       return 3'd5;
    if (k < len - 4)  return 3'd6;
    return 3'd7;
  endfunction

  // Frame body; badAt >= 0 corrupts that destination byte against matchMac
  task automatic buildFrame(input int len, input int badAt);
    for (int k = 0; k < len; k++) begin
      frm[k] = 8'($urandom);
      if (k < MAC_BYTES && matchMac != '0) frm[k] = macByte(k);
      if (k == badAt) frm[k] = macByte(k) ^ 8'h5A;
      fld[k] = fieldOf(k, len);
    end
  endtask

  task automatic setCfg(input bit en, input int cnt, input int pos,
                        input logic [7:0] val, input logic [MAC_W-1:0] mac);
    @(negedge clk);
    cmdEnable     = en;
    cmdFrameCount = CNT_W'(cnt);
    cmdBytePos    = POS_W'(pos);
    cmdNewValue   = val;
    matchMac      = mac;
  endtask

  task automatic dropEnable();
    @(negedge clk);
    cmdEnable = 1'b0;
    @(negedge clk);
    mDone = 0;
    mCount = 0;
    check(testDone == 1'b0, "R4", "testDone after withdrawal", int'(testDone), 0);
  endtask

  // Sends one frame; at body byte chgAt the enable is forced to chgVal
  task automatic sendFrame(input int len, input int chgAt, input bit chgVal, input string tag);
    bit sel, prefix, hit, fixExp, cond, inWin, eq, macOk, rep, expDelay;
    int need;
    logic [7:0] expByte;
    prefix = 1; hit = 0; fixExp = 0;
    @(negedge clk);
    rxFrameActive = 1'b1;
    sel = cmdEnable && !mDone;
    for (int i = 0; i < 8; i++) begin
      rxByteIn     = (i == 7) ? 8'hD5 : 8'h55;
      rxFieldState = (i == 7) ? 3'd2 : 3'd1;
      rxStrobeIn   = 1'b1;
      @(negedge clk);
      rxStrobeIn = 1'b0;
      @(negedge clk);
    end
    for (int k = 0; k < len; k++) begin
      if (k == chgAt) begin
        cmdEnable = chgVal;
        if (!chgVal) begin mDone = 0; mCount = 0; end
      end
      cond     = (matchMac != '0);
      inWin    = (k < MAC_BYTES);
      eq       = inWin && (frm[k] == macByte(k));
      macOk    = !cond || (prefix && (!inWin || eq));
      rep      = sel && cmdEnable && !hit && (k == int'(cmdBytePos)) && macOk;
      expDelay = sel && cmdEnable && cond && inWin && prefix;
      expByte  = rep ? cmdNewValue : frm[k];
      if (rep) begin
        hit = 1; fixExp = 1; mCount++;
        need = (cmdFrameCount == 0) ? 1 : int'(cmdFrameCount);
        if (mCount >= need) mDone = 1;
      end
      if (inWin && !eq) prefix = 0;
      rxByteIn     = frm[k];
      rxFieldState = fld[k];
      rxStrobeIn   = 1'b1;
      @(negedge clk);
      check(rxByteOut == expByte, tag, "byte out", int'(rxByteOut), int'(expByte));
      check(rxStrobeOut == 1'b1, "R1", "strobe high", int'(rxStrobeOut), 1);
      check(delayByte == expDelay, cond ? "R7" : "R5", "delayByte", int'(delayByte), int'(expDelay));
      check(fixChecksum == fixExp, "R8", "fixChecksum in frame", int'(fixChecksum), int'(fixExp));
      check(testDone == mDone, "R9", "testDone in frame", int'(testDone), int'(mDone));
      rxStrobeIn = 1'b0;
      @(negedge clk);
      check(rxStrobeOut == 1'b0, "R1", "strobe low", int'(rxStrobeOut), 0);
    end
    rxFrameActive = 1'b0;
    rxFieldState  = 3'd0;
    rxByteIn      = 8'h00;
    @(negedge clk);
    check(fixChecksum == 1'b0, "R8", "fixChecksum after end", int'(fixChecksum), 0);
    check(testDone == mDone, "R9", "testDone after end", int'(testDone), int'(mDone));
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog: actual 200000 cycles expected fewer");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [MAC_W-1:0] macA;
    void'($urandom(32'h5EED_1234));
    macA = 48'h02_1A_2B_3C_4D_5E;

    // Reset state (R10)
    repeat (3) @(negedge clk);
    check(rxByteOut == 8'h00 && rxStrobeOut == 1'b0, "R10", "data outputs in reset",
          int'(rxByteOut), 0);
    check(fixChecksum == 1'b0 && delayByte == 1'b0 && testDone == 1'b0, "R10",
          "flags in reset", int'({fixChecksum, delayByte, testDone}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Disabled: frames pass through (R1)
    setCfg(0, 1, 10, 8'hA5, '0);
    for (int f = 0; f < 2; f++) begin
      buildFrame(40, -1);
      sendFrame(40, -1, 0, "R1");
    end

    // Unconditional, two frames, mid position (R2, R9)
    setCfg(1, 2, 14, 8'h3C, '0);
    for (int f = 0; f < 3; f++) begin
      buildFrame(50, -1);
      sendFrame(50, -1, 0, "R2");
    end
    dropEnable();

    // Position 0 boundary (R2)
    setCfg(1, 1, 0, 8'hE7, '0);
    buildFrame(30, -1);
    sendFrame(30, -1, 0, "R2");
    dropEnable();

    // Enable rises during a frame: that frame untouched, next one changed (R3)
    setCfg(0, 1, 20, 8'h11, '0);
    buildFrame(40, -1);
    sendFrame(40, 5, 1, "R3");
    buildFrame(40, -1);
    sendFrame(40, -1, 0, "R3");
    dropEnable();

    // Enable withdrawn before the position is reached (R4)
    setCfg(1, 1, 25, 8'h22, '0);
    buildFrame(40, -1);
    sendFrame(40, 10, 0, "R4");

    // Short frame not counted, then a long one finishes (R9)
    setCfg(1, 1, 50, 8'h33, '0);
    buildFrame(30, -1);
    sendFrame(30, -1, 0, "R9");
    buildFrame(70, -1);
    sendFrame(70, -1, 0, "R9");
    dropEnable();

    // Count of zero acts as one (R9)
    setCfg(1, 0, 8, 8'h44, '0);
    buildFrame(30, -1);
    sendFrame(30, -1, 0, "R9");
    buildFrame(30, -1);
    sendFrame(30, -1, 0, "R9");
    dropEnable();

    // Conditional, position past the address (R6)
    setCfg(1, 1, 20, 8'h55, macA);
    buildFrame(40, 3);
    sendFrame(40, -1, 0, "R6");
    buildFrame(40, 5);
    sendFrame(40, -1, 0, "R6");
    buildFrame(40, -1);
    sendFrame(40, -1, 0, "R6");
    dropEnable();

    // Conditional, position inside the address (R7)
    setCfg(1, 2, 2, 8'h66, macA);
    buildFrame(30, 4);
    sendFrame(30, -1, 0, "R7");
    buildFrame(30, 1);
    sendFrame(30, -1, 0, "R7");
    buildFrame(30, 2);
    sendFrame(30, -1, 0, "R7");
    buildFrame(30, -1);
    sendFrame(30, -1, 0, "R7");
    dropEnable();

    // Seeded random mix (R2, R6)
    for (int t = 0; t < 30; t++) begin
      logic [MAC_W-1:0] mac;
      int len;
      int bad;
      mac = ($urandom % 2 == 0) ? '0 : {16'($urandom), 32'($urandom)};
      setCfg(1, 1 + int'($urandom % 3), int'($urandom % 40), 8'($urandom), mac);
      for (int f = 0; f < 5; f++) begin
        len = 20 + int'($urandom % 50);
        bad = ($urandom % 3 == 0) ? int'($urandom % 6) : -1;
        buildFrame(len, bad);
        sendFrame(len, -1, 0, (mac != '0) ? "R6" : "R2");
      end
      dropEnable();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule